// File: doc/BRIEF.md
# GPIO Port Controller

A register-based general-purpose I/O port that sits on a simple memory-mapped bus (address, write enable, write data, read enable, read data). Software sees four word registers: a level register that returns the synchronized pad levels, a write-one-to-set register, a write-one-to-clear register and a direction register. The block drives a per-line output value and a per-line output enable toward the pad ring, and samples the pad inputs through a two-flop synchronizer.

Elaboration parameters choose the register width (and so the number of lines), whether a 1 in the direction register means output or means input, whether line n maps to bus bit n or to bus bit (width − 1 − n), and whether the set/clear pair exists. Without the pair, a write to the level register loads the whole output latch at once. Read data is registered: it appears one clock after the read request and is zero in any cycle that follows no read.

Top module: `gpio_port`

## Requirements
- R1: The register width REG_W is 8, 16, 32 or 64 and the port has REG_W lines; word offsets are 0 level, 1 set, 2 clear, 3 direction, and other parameter values are rejected at elaboration.
- R2: After reset the output latch is 0, every line is an input so pad_oe is all zero in either polarity, and rd_data is 0.
- R3: A read of offset 0 returns the pad levels after a two-flop synchronizer: a pad change made before edge A is still old for a read captured at edge A and is seen by a read captured at edge C, two edges later.
- R4: Writing offset 1 drives a 1 onto each line whose write-data bit is 1; other lines keep their value.
- R5: Writing offset 2 drives a 0 onto each line whose write-data bit is 1; other lines keep their value.
- R6: Reading offset 1 returns the latched output values, not the pad levels.
- R7: With DIR_IS_OUT = 1 a 1 in the direction register enables that line's output; with DIR_IS_OUT = 0 a 1 makes it an input; the direction register reads back as written.
- R8: With MIRROR = 1, line n corresponds to bus bit REG_W − 1 − n in every register, for writes and reads alike.
- R9: With HAS_SETCLR = 0, a write to offset 0 loads the output latch directly, and offsets 1 and 2 behave as unmapped.
- R10: A read of an unmapped offset, or of the write-only clear register, returns 0; writes to unmapped offsets change nothing; rd_data is 0 in a cycle after no read.
- R11: With HAS_SETCLR = 1, writes to offset 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word offset of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | REG_W | Write data in bus bit order |
| rd_en | input | 1 | Read strobe |
| rd_data | output | REG_W | Registered read data, valid the cycle after rd_en |
| pad_in | input | REG_W | Pad input levels, line order |
| pad_out | output | REG_W | Output latch value per line |
| pad_oe | output | REG_W | Output enable per line |

## Verification
The hardest situation to bring about from the ports is the synchronizer window, where a read lands while a pad change is still inside the two flops; the bench changes the pad and holds a read request across three consecutive edges, checking the first result is the old level and the third is the new one. The mirrored, input-polarity, no-set/clear variant is built as a second instance, so that bit reversal, inverted enables and the direct latch load are observed at the pads with asymmetric patterns that a missing reversal would not hide.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int unsigned OFS_LEVEL = 0;
   localparam int unsigned OFS_SET   = 1;
   localparam int unsigned OFS_CLEAR = 2;
   localparam int unsigned OFS_DIR   = 3;

   typedef enum logic [1:0] {
      SEL_LEVEL,
      SEL_SET,
      SEL_CLEAR,
      SEL_DIR
   } gpio_sel_e;

   typedef struct packed {
      logic      hit;    // offset is mapped for reads
      logic      wr_ok;  // offset accepts writes
      gpio_sel_e sel;
   } gpio_dec_t;
endpackage

// File: rtl/gpio_bit_map.sv
// Maps between bus bit order and line order; the mapping is its own inverse.
module gpio_bit_map #(
   parameter int unsigned W      = 16,
   parameter int unsigned MIRROR = 0
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (MIRROR != 0) begin : g_mirror
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign dout[i] = din[W-1-i];
      end
   end else begin : g_straight
      assign dout = din;
   end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned W      = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pad_in,
   output logic [W-1:0] level
);
   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= pad_in;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign level = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
   import gpio_port_pkg::*;
#(
   parameter int unsigned W          = 16,
   parameter int unsigned DIR_IS_OUT = 1,
   parameter int unsigned HAS_SETCLR = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  gpio_dec_t    dec,
   input  logic [W-1:0] wr_line,
   output logic [W-1:0] latch_q,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] oe
);
   localparam logic [W-1:0] DIR_RESET = (DIR_IS_OUT != 0) ? '0 : '1;
   localparam bit           SETCLR    = (HAS_SETCLR != 0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= DIR_RESET;
      end else if (wr_en && dec.wr_ok) begin
         case (dec.sel)
            SEL_LEVEL: if (!SETCLR) latch_q <= wr_line;
            SEL_SET:   if (SETCLR)  latch_q <= latch_q | wr_line;
            SEL_CLEAR: if (SETCLR)  latch_q <= latch_q & ~wr_line;
            SEL_DIR:   dir_q <= wr_line;
            default:   ;
         endcase
      end
   end

   if (DIR_IS_OUT != 0) begin : g_dir_out
      assign oe = dir_q;
   end else begin : g_dir_in
      assign oe = ~dir_q;
   end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_port_pkg::*;
#(
   parameter int unsigned REG_W      = 16,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DIR_IS_OUT = 1,
   parameter int unsigned MIRROR     = 0,
   parameter int unsigned HAS_SETCLR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              rd_en,
   output logic [REG_W-1:0]  rd_data,
   input  logic [REG_W-1:0]  pad_in,
   output logic [REG_W-1:0]  pad_out,
   output logic [REG_W-1:0]  pad_oe
);
   localparam bit SETCLR = (HAS_SETCLR != 0);

   // R1: elaboration-time parameter checks
   if (!(REG_W == 8 || REG_W == 16 || REG_W == 32 || REG_W == 64)) begin : g_bad_width
      $error("gpio_port: REG_W must be 8, 16, 32 or 64");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("gpio_port: ADDR_W must cover four word offsets");
   end
   if (DIR_IS_OUT > 1 || MIRROR > 1 || HAS_SETCLR > 1) begin : g_bad_flag
      $error("gpio_port: option parameters must be 0 or 1");
   end

   gpio_dec_t          dec;
   logic [REG_W-1:0]   wr_line;
   logic [REG_W-1:0]   lvl_line, lvl_bus;
   logic [REG_W-1:0]   latch_line, latch_bus;
   logic [REG_W-1:0]   dir_line, dir_bus;
   logic [REG_W-1:0]   rd_mux;

   always_comb begin
      dec = '{hit: 1'b0, wr_ok: 1'b0, sel: SEL_LEVEL};
      case (addr)
         ADDR_W'(OFS_LEVEL): dec = '{hit: 1'b1,   wr_ok: !SETCLR, sel: SEL_LEVEL};
         ADDR_W'(OFS_SET):   dec = '{hit: SETCLR, wr_ok: SETCLR,  sel: SEL_SET};
         ADDR_W'(OFS_CLEAR): dec = '{hit: 1'b0,   wr_ok: SETCLR,  sel: SEL_CLEAR};
         ADDR_W'(OFS_DIR):   dec = '{hit: 1'b1,   wr_ok: 1'b1,    sel: SEL_DIR};
         default:            ;
      endcase
   end

   gpio_bit_map #(.W(REG_W), .MIRROR(MIRROR)) i_map_wr (.din(wr_data),    .dout(wr_line));
   gpio_bit_map #(.W(REG_W), .MIRROR(MIRROR)) i_map_lv (.din(lvl_line),   .dout(lvl_bus));
   gpio_bit_map #(.W(REG_W), .MIRROR(MIRROR)) i_map_lt (.din(latch_line), .dout(latch_bus));
   gpio_bit_map #(.W(REG_W), .MIRROR(MIRROR)) i_map_dr (.din(dir_line),   .dout(dir_bus));

   gpio_in_sync #(.W(REG_W), .STAGES(2)) i_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pad_in (pad_in),
      .level  (lvl_line)
   );

   gpio_out_regs #(.W(REG_W), .DIR_IS_OUT(DIR_IS_OUT), .HAS_SETCLR(HAS_SETCLR)) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .dec     (dec),
      .wr_line (wr_line),
      .latch_q (latch_line),
      .dir_q   (dir_line),
      .oe      (pad_oe)
   );

   assign pad_out = latch_line;

   always_comb begin
      case (dec.sel)
         SEL_LEVEL: rd_mux = lvl_bus;
         SEL_SET:   rd_mux = latch_bus;
         SEL_DIR:   rd_mux = dir_bus;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rd_data <= '0;
      else if (rd_en && dec.hit) rd_data <= rd_mux;
      else                       rd_data <= '0;
   end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
   import gpio_port_pkg::*;
#(
   parameter int unsigned REG_W      = 16,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DIR_IS_OUT = 1,
   parameter int unsigned MIRROR     = 0,
   parameter int unsigned HAS_SETCLR = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic [REG_W-1:0]  wr_data,
   input logic              rd_en,
   input logic [REG_W-1:0]  rd_data,
   input logic [REG_W-1:0]  pad_out,
   input logic [REG_W-1:0]  pad_oe
);
   function automatic logic [REG_W-1:0] to_line(input logic [REG_W-1:0] v);
      logic [REG_W-1:0] r;
      for (int i = 0; i < REG_W; i++) r[i] = (MIRROR != 0) ? v[REG_W-1-i] : v[i];
      return r;
   endfunction

   logic sc, at_lvl, at_set, at_clr, at_dir, out_write, readable;
   assign sc        = (HAS_SETCLR != 0);
   assign at_lvl    = (addr == ADDR_W'(OFS_LEVEL));
   assign at_set    = (addr == ADDR_W'(OFS_SET));
   assign at_clr    = (addr == ADDR_W'(OFS_CLEAR));
   assign at_dir    = (addr == ADDR_W'(OFS_DIR));
   assign out_write = wr_en && (sc ? (at_set || at_clr) : at_lvl);
   assign readable  = at_lvl || at_dir || (sc && at_set);

   AST_SET_DRIVES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (sc && wr_en && at_set) |=> ((pad_out & to_line($past(wr_data))) == to_line($past(wr_data)))); // R4

   AST_CLR_DRIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sc && wr_en && at_clr) |=> ((pad_out & to_line($past(wr_data))) == '0)); // R5

   AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !out_write |=> $stable(pad_out)); // R11

   AST_LEVEL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (!sc && wr_en && at_lvl) |=> (pad_out == to_line($past(wr_data)))); // R9

   AST_DIR_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && at_dir) |=> (pad_oe == ((DIR_IS_OUT != 0) ? to_line($past(wr_data))
                                                          : ~to_line($past(wr_data))))); // R7

   AST_OE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && at_dir) |=> $stable(pad_oe)); // R7

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !readable) |=> (rd_data == '0)); // R10

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rd_data == '0)); // R10
endmodule

bind gpio_port gpio_port_chk #(
   .REG_W(REG_W), .ADDR_W(ADDR_W), .DIR_IS_OUT(DIR_IS_OUT),
   .MIRROR(MIRROR), .HAS_SETCLR(HAS_SETCLR)
) i_gpio_port_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
   .rd_en(rd_en), .rd_data(rd_data), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic        rd_en = 1'b0;
   logic        wr_en_a = 1'b0, wr_en_b = 1'b0;
   logic [15:0] pad_in_a = '0, pad_out_a, pad_oe_a, rd_data_a;
   logic [7:0]  pad_in_b = '0, pad_out_b, pad_oe_b, rd_data_b;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   // A: 16 lines, 1 = output, straight order, set/clear pair present
   gpio_port #(.REG_W(16), .ADDR_W(4), .DIR_IS_OUT(1), .MIRROR(0), .HAS_SETCLR(1)) i_gpio_port (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en_a), .wr_data(wdata),
      .rd_en(rd_en), .rd_data(rd_data_a), .pad_in(pad_in_a), .pad_out(pad_out_a), .pad_oe(pad_oe_a));

   // B: 8 lines, 1 = input, mirrored order, no set/clear pair
   gpio_port #(.REG_W(8), .ADDR_W(4), .DIR_IS_OUT(0), .MIRROR(1), .HAS_SETCLR(0)) i_gpio_port_b (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en_b), .wr_data(wdata[7:0]),
      .rd_en(rd_en), .rd_data(rd_data_b), .pad_in(pad_in_b), .pad_out(pad_out_b), .pad_oe(pad_oe_b));

   typedef struct packed {
      logic        rd;
      logic [3:0]  a;
      logic [15:0] wd;
      logic [15:0] pad;
      logic [15:0] out;
      logic [15:0] oe;
      logic [15:0] rdv;
      logic [7:0]  req;
   } vec_t;

   // Walked on instance A; req is the requirement number exercised.
   localparam vec_t VEC [0:11] = '{
      '{1'b0, 4'd3, 16'hFF00, 16'h0000, 16'h0000, 16'hFF00, 16'h0000, 8'd7 },  // R7 dir write, R1 offset 3
      '{1'b0, 4'd1, 16'h0F0F, 16'h0000, 16'h0F0F, 16'hFF00, 16'h0000, 8'd4 },  // R4
      '{1'b0, 4'd2, 16'h0301, 16'h0000, 16'h0C0E, 16'hFF00, 16'h0000, 8'd5 },  // R5
      '{1'b0, 4'd1, 16'h0000, 16'h0000, 16'h0C0E, 16'hFF00, 16'h0000, 8'd4 },  // R4 zeros keep
      '{1'b1, 4'd1, 16'h0000, 16'hA5A5, 16'h0C0E, 16'hFF00, 16'h0C0E, 8'd6 },  // R6
      '{1'b1, 4'd0, 16'h0000, 16'hA5A5, 16'h0C0E, 16'hFF00, 16'hA5A5, 8'd3 },  // R3
      '{1'b0, 4'd0, 16'hFFFF, 16'hA5A5, 16'h0C0E, 16'hFF00, 16'h0000, 8'd11},  // R11
      '{1'b1, 4'd3, 16'h0000, 16'hA5A5, 16'h0C0E, 16'hFF00, 16'hFF00, 8'd7 },  // R7 readback
      '{1'b1, 4'd5, 16'h0000, 16'hA5A5, 16'h0C0E, 16'hFF00, 16'h0000, 8'd10},  // R10
      '{1'b0, 4'd6, 16'hFFFF, 16'hA5A5, 16'h0C0E, 16'hFF00, 16'h0000, 8'd10},  // R10
      '{1'b0, 4'd2, 16'hFFFF, 16'hA5A5, 16'h0000, 16'hFF00, 16'h0000, 8'd5 },  // R5
      '{1'b1, 4'd2, 16'h0000, 16'hA5A5, 16'h0000, 16'hFF00, 16'h0000, 8'd10}   // R10 clear is write-only
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_op(input logic rd, input logic wa, input logic wb,
                         input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      addr = a; wdata = d; rd_en = rd; wr_en_a = wa; wr_en_b = wb;
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b0; wr_en_a = 1'b0; wr_en_b = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 reset state
      chk("R2 pad_out A", pad_out_a, 0);
      chk("R2 pad_oe A", pad_oe_a, 0);
      chk("R2 rd_data A", rd_data_a, 0);
      chk("R2 pad_oe B (input polarity)", pad_oe_b, 0);

      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         pad_in_a = VEC[i].pad;
         repeat (3) @(negedge clk);
         bus_op(VEC[i].rd, !VEC[i].rd, 1'b0, VEC[i].a, VEC[i].wd);
         chk($sformatf("R%0d vec %0d pad_out", VEC[i].req, i), pad_out_a, VEC[i].out);
         chk($sformatf("R%0d vec %0d pad_oe", VEC[i].req, i), pad_oe_a, VEC[i].oe);
         if (VEC[i].rd)
            chk($sformatf("R%0d vec %0d rd_data", VEC[i].req, i), rd_data_a, VEC[i].rdv);
      end

      // R3 synchronizer window: read held over three edges after a pad change
      @(negedge clk);
      pad_in_a = 16'h1234; addr = 4'd0; rd_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R3 first edge still old", rd_data_a, 16'hA5A5);
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b0;
      chk("R3 third edge new level", rd_data_a, 16'h1234);
      @(negedge clk);
      chk("R10 idle read data zero", rd_data_a, 0);

      // Instance B: input polarity, mirrored, direct latch load
      bus_op(1'b1, 1'b0, 1'b0, 4'd3, 16'h0000);
      chk("R7 R2 B dir resets all-input", rd_data_b, 8'hFF);
      bus_op(1'b0, 1'b0, 1'b1, 4'd3, 16'h0080);   // bus bit 7 -> line 0 input
      chk("R7 R8 B oe", pad_oe_b, 8'hFE);
      bus_op(1'b0, 1'b0, 1'b1, 4'd0, 16'h0003);   // bus bits 0,1 -> lines 7,6
      chk("R9 R8 B direct load", pad_out_b, 8'hC0);
      bus_op(1'b0, 1'b0, 1'b1, 4'd1, 16'h00FF);
      chk("R9 B set offset unmapped", pad_out_b, 8'hC0);
      bus_op(1'b0, 1'b0, 1'b1, 4'd2, 16'h00FF);
      chk("R9 B clear offset unmapped", pad_out_b, 8'hC0);
      bus_op(1'b1, 1'b0, 1'b0, 4'd1, 16'h0000);
      chk("R9 B set offset reads zero", rd_data_b, 8'h00);
      @(negedge clk);
      pad_in_b = 8'h01;                           // line 0 high
      repeat (3) @(negedge clk);
      bus_op(1'b1, 1'b0, 1'b0, 4'd0, 16'h0000);
      chk("R8 R3 B mirrored level", rd_data_b, 8'h80);
      chk("R1 A untouched by B writes", pad_out_a, 16'h0000);

      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule